// File: doc/BRIEF.md
# Serial channel clock output generator

This block drives the clock outputs of one serial channel from a bit-rate tick made elsewhere. Each tick toggles the transmit clock and the receive clock by half a bit period. The block also produces two single-cycle strobes. One marks the transmit clock edge on which transmit data is allowed to change. The other marks the receive clock edge on which receive data is sampled.

Both clocks stay parked at a fixed level after reset. Each one starts only once its direction has been enabled, and from then on it runs whatever the enable does. In asynchronous line mode the receive clock moves only while the receiver reports that a character is in progress, and it freezes during the fill between characters. The transmit pin can be given a second function: instead of the clock, it shows an active-low ready indication that compares the receive FIFO fill level against a programmable threshold. The receive clock output can also be parked when the channel takes its receive clock from outside.

Top module: `ser_clkout_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `txc_dtr_o` is 1, `rxc_o` is 0, and both strobes are 0.
- R2: The transmit clock stays at 1 until `tx_en_i` has been sampled high at a clock edge. The first toggle can happen on a tick sampled at the following edge.
- R3: Once armed, the transmit clock toggles at the clock edge of every tick. This holds after `tx_en_i` returns low, in both line modes, and whether or not a character is in progress.
- R4: `tx_shift_stb_o` is high for exactly the cycles in which the transmit clock has just gone from 1 to 0. It pulses on every such transition, including while the pin shows the ready function.
- R5: The receive clock stays at 0 until `rx_en_i` has been sampled high at a clock edge. After that it runs on ticks whatever the later value of `rx_en_i`.
- R6: `line_mode_i` = 0 selects asynchronous mode, where an armed receive clock toggles on a tick only while `rx_char_i` is 1 and otherwise keeps its level. `line_mode_i` = 1 selects synchronous mode, where it toggles on every tick.
- R7: `rx_sample_stb_o` is high for exactly the cycles in which the receive clock has just gone from 0 to 1.
- R8: With `txpin_fn_i` = 1, `txc_dtr_o` carries the ready indication. It is 0 in the cycle after an edge at which `rxf_level_i` >= `dtr_thresh_i`, and 1 in the cycle after an edge at which the level is below the threshold. With `txpin_fn_i` = 0 the pin shows the transmit clock, which keeps running underneath the whole time.
- R9: While `ext_rxclk_i` is 1, the receive clock is forced to 0 from the next edge on and no sample strobe is produced. When it is cleared, the clock resumes from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | Half-bit tick; each tick toggles the running clocks |
| tx_en_i | input | 1 | Transmit direction enable |
| rx_en_i | input | 1 | Receive direction enable |
| line_mode_i | input | 1 | 0 = asynchronous, 1 = synchronous |
| rx_char_i | input | 1 | Receiver reports a character in progress |
| ext_rxclk_i | input | 1 | External receive clock selected; parks the receive clock output |
| txpin_fn_i | input | 1 | Transmit pin function: 0 = clock, 1 = ready indication |
| rxf_level_i | input | CNT_W | Receive FIFO fill level |
| dtr_thresh_i | input | CNT_W | Ready threshold |
| txc_dtr_o | output | 1 | Transmit clock or active-low ready pin |
| rxc_o | output | 1 | Receive clock output |
| tx_shift_stb_o | output | 1 | Transmit data change strobe (falling edge) |
| rx_sample_stb_o | output | 1 | Receive sample strobe (rising edge) |

## Verification
The bench first lets ticks run before either enable arrives. A design that started its clocks on reset release, or armed them on the tick alone, would show toggles in that window. It then pulses each enable for a single cycle and keeps ticking. A design whose arming is not sticky would freeze one cycle later. In asynchronous mode the receive clock is stopped while it is high, to catch a design that drops the clock to idle or keeps counting through the fill gap. The ready pin is driven with levels below, equal to and above the threshold, to catch an off-by-one in the compare. The external clock select is raised while the receive clock is high, to catch a design that leaks a strobe or holds the old level.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
   typedef enum logic {
      LINE_ASYNC = 1'b0,
      LINE_SYNC  = 1'b1
   } line_mode_e;

   typedef enum logic {
      PIN_CLOCK = 1'b0,
      PIN_READY = 1'b1
   } txpin_fn_e;

   localparam logic TXC_PARK_LVL = 1'b1;
   localparam logic RXC_PARK_LVL = 1'b0;
endpackage

// File: rtl/sclk_arm_latch.sv
module sclk_arm_latch (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic armed_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   armed_o <= 1'b0;
      else if (en_i) armed_o <= 1'b1;
   end
endmodule

// File: rtl/sclk_tx_unit.sv
module sclk_tx_unit
   import sclk_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic armed_i,
   input  logic tick_i,
   output logic txc_o,
   output logic shift_stb_o
);
   logic flip;
   assign flip = armed_i & tick_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         txc_o       <= TXC_PARK_LVL;
         shift_stb_o <= 1'b0;
      end else begin
         shift_stb_o <= flip & txc_o;
         if (flip) txc_o <= ~txc_o;
      end
   end
endmodule

// File: rtl/sclk_rx_unit.sv
module sclk_rx_unit
   import sclk_pkg::*;
#(
   parameter bit EXT_RXCLK_EN = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       armed_i,
   input  logic       tick_i,
   input  line_mode_e mode_i,
   input  logic       char_active_i,
   input  logic       ext_sel_i,
   output logic       rxc_o,
   output logic       sample_stb_o
);
   logic gate_open;
   logic flip;
   logic parked;

   assign gate_open = (mode_i == LINE_SYNC) | char_active_i;
   assign flip      = armed_i & tick_i & gate_open;

   generate
      if (EXT_RXCLK_EN) begin : g_ext
         assign parked = ext_sel_i;
      end else begin : g_no_ext
         logic unused_ext;
         assign unused_ext = ext_sel_i;
         assign parked     = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rxc_o        <= RXC_PARK_LVL;
         sample_stb_o <= 1'b0;
      end else if (parked) begin
         rxc_o        <= RXC_PARK_LVL;
         sample_stb_o <= 1'b0;
      end else begin
         sample_stb_o <= flip & ~rxc_o;
         if (flip) rxc_o <= ~rxc_o;
      end
   end
endmodule

// File: rtl/sclk_dtr_unit.sv
module sclk_dtr_unit #(
   parameter int CNT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] level_i,
   input  logic [CNT_W-1:0] thresh_i,
   output logic             ready_no
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ready_no <= 1'b1;
      else         ready_no <= ~(level_i >= thresh_i);
   end
endmodule

// File: rtl/ser_clkout_gen.sv
module ser_clkout_gen
   import sclk_pkg::*;
#(
   parameter int CNT_W        = 6,
   parameter bit EXT_RXCLK_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             bit_tick_i,
   input  logic             tx_en_i,
   input  logic             rx_en_i,
   input  logic             line_mode_i,
   input  logic             rx_char_i,
   input  logic             ext_rxclk_i,
   input  logic             txpin_fn_i,
   input  logic [CNT_W-1:0] rxf_level_i,
   input  logic [CNT_W-1:0] dtr_thresh_i,
   output logic             txc_dtr_o,
   output logic             rxc_o,
   output logic             tx_shift_stb_o,
   output logic             rx_sample_stb_o
);
   localparam int MAX_CNT_W = 16;

   generate
      if (CNT_W < 1 || CNT_W > MAX_CNT_W) begin : g_bad_cnt_w
         $error("ser_clkout_gen: CNT_W out of range");
      end
   endgenerate

   logic      tx_armed;
   logic      rx_armed;
   logic      txc_int;
   logic      ready_n;
   txpin_fn_e pin_fn;

   assign pin_fn = txpin_fn_e'(txpin_fn_i);

   sclk_arm_latch u_tx_arm (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tx_en_i), .armed_o(tx_armed)
   );

   sclk_arm_latch u_rx_arm (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .armed_o(rx_armed)
   );

   sclk_tx_unit u_tx (
      .clk_i(clk_i), .rst_ni(rst_ni), .armed_i(tx_armed), .tick_i(bit_tick_i),
      .txc_o(txc_int), .shift_stb_o(tx_shift_stb_o)
   );

   sclk_rx_unit #(.EXT_RXCLK_EN(EXT_RXCLK_EN)) u_rx (
      .clk_i(clk_i), .rst_ni(rst_ni), .armed_i(rx_armed), .tick_i(bit_tick_i),
      .mode_i(line_mode_e'(line_mode_i)), .char_active_i(rx_char_i),
      .ext_sel_i(ext_rxclk_i), .rxc_o(rxc_o), .sample_stb_o(rx_sample_stb_o)
   );

   sclk_dtr_unit #(.CNT_W(CNT_W)) u_dtr (
      .clk_i(clk_i), .rst_ni(rst_ni), .level_i(rxf_level_i),
      .thresh_i(dtr_thresh_i), .ready_no(ready_n)
   );

   assign txc_dtr_o = (pin_fn == PIN_READY) ? ready_n : txc_int;
endmodule

// File: rtl/sclk_clkout_chk.sv
module sclk_clkout_chk #(
   parameter int CNT_W        = 6,
   parameter bit EXT_RXCLK_EN = 1'b1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             bit_tick_i,
   input logic             line_mode_i,
   input logic             rx_char_i,
   input logic             ext_rxclk_i,
   input logic             txpin_fn_i,
   input logic [CNT_W-1:0] rxf_level_i,
   input logic [CNT_W-1:0] dtr_thresh_i,
   input logic             tx_armed,
   input logic             rx_armed,
   input logic             txc_int,
   input logic             txc_dtr_o,
   input logic             rxc_o,
   input logic             tx_shift_stb_o,
   input logic             rx_sample_stb_o
);
   a_r2_tx_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tx_armed |-> txc_int);

   a_r3_tx_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_armed && bit_tick_i) |=> (txc_int != $past(txc_int)));

   a_r4_fall_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_shift_stb_o |-> (!txc_int && $past(txc_int)));

   a_r5_rx_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rx_armed |-> !rxc_o);

   a_r6_async_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!line_mode_i && !rx_char_i && !ext_rxclk_i) |=> $stable(rxc_o));

   a_r7_rise_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_sample_stb_o |-> (rxc_o && !$past(rxc_o)));

   a_r8_ready_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && txpin_fn_i) |->
         (txc_dtr_o == ($past(rxf_level_i) < $past(dtr_thresh_i))));

   generate
      if (EXT_RXCLK_EN) begin : g_ext_chk
         a_r9_ext_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ext_rxclk_i |=> (!rxc_o && !rx_sample_stb_o));
      end
   endgenerate
endmodule

bind ser_clkout_gen sclk_clkout_chk #(.CNT_W(CNT_W), .EXT_RXCLK_EN(EXT_RXCLK_EN)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .bit_tick_i(bit_tick_i),
   .line_mode_i(line_mode_i), .rx_char_i(rx_char_i), .ext_rxclk_i(ext_rxclk_i),
   .txpin_fn_i(txpin_fn_i), .rxf_level_i(rxf_level_i), .dtr_thresh_i(dtr_thresh_i),
   .tx_armed(tx_armed), .rx_armed(rx_armed), .txc_int(txc_int),
   .txc_dtr_o(txc_dtr_o), .rxc_o(rxc_o), .tx_shift_stb_o(tx_shift_stb_o),
   .rx_sample_stb_o(rx_sample_stb_o)
);

// File: tb/test_ser_clkout_gen.sv
`timescale 1ns/1ps
module test_ser_clkout_gen;
   localparam int CNT_W = 6;

   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic tick = 1'b0, tx_en = 1'b0, rx_en = 1'b0, mode = 1'b0;
   logic rx_char = 1'b0, ext = 1'b0, fn = 1'b0;
   logic [CNT_W-1:0] level = '0, thresh = '0;
   logic pin, rxc, txs, rxs;

   always #4 clk = ~clk;

   ser_clkout_gen #(.CNT_W(CNT_W), .EXT_RXCLK_EN(1'b1)) i_ser_clkout_gen (
      .clk_i(clk), .rst_ni(rst_ni), .bit_tick_i(tick), .tx_en_i(tx_en),
      .rx_en_i(rx_en), .line_mode_i(mode), .rx_char_i(rx_char),
      .ext_rxclk_i(ext), .txpin_fn_i(fn), .rxf_level_i(level),
      .dtr_thresh_i(thresh), .txc_dtr_o(pin), .rxc_o(rxc),
      .tx_shift_stb_o(txs), .rx_sample_stb_o(rxs)
   );

   typedef struct {
      logic  pin;
      logic  rxc;
      logic  txs;
      logic  rxs;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   logic m_ta = 1'b0, m_ra = 1'b0, m_txc = 1'b1, m_rxc = 1'b0, m_rdy = 1'b1;

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic drive(input logic tk, input logic te, input logic re, input logic md,
                        input logic rc, input logic ex, input logic f,
                        input int lvl, input int thr, input string tag);
      exp_t e;
      logic tog_t, tog_r, s_t, s_r;
      @(negedge clk);
      tick = tk; tx_en = te; rx_en = re; mode = md; rx_char = rc; ext = ex; fn = f;
      level = CNT_W'(lvl); thresh = CNT_W'(thr);
      tog_t = m_ta & tk;
      s_t   = tog_t & m_txc;
      if (tog_t) m_txc = ~m_txc;
      m_ta = m_ta | te;
      if (ex) begin
         m_rxc = 1'b0; s_r = 1'b0;
      end else begin
         tog_r = m_ra & tk & (md | rc);
         s_r   = tog_r & ~m_rxc;
         if (tog_r) m_rxc = ~m_rxc;
      end
      m_ra  = m_ra | re;
      m_rdy = !(lvl >= thr);
      e.pin = f ? m_rdy : m_txc;
      e.rxc = m_rxc; e.txs = s_t; e.rxs = s_r; e.tag = tag;
      exp_q.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk({e.tag, " pin"}, pin, e.pin);
            chk({e.tag, " rx clock"}, rxc, e.rxc);
            chk({e.tag, " tx strobe (R4)"}, txs, e.txs);
            chk({e.tag, " rx strobe (R7)"}, rxs, e.rxs);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stimulus
      repeat (2) @(posedge clk);
      // R1: levels during reset
      #1;
      chk("R1 pin in reset", pin, 1'b1);
      chk("R1 rx clock in reset", rxc, 1'b0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_ni = 1'b1;
      #1;
      chk("R1 pin after release", pin, 1'b1);
      chk("R1 rx clock after release", rxc, 1'b0);
      chk("R1 tx strobe after release", txs, 1'b0);
      chk("R1 rx strobe after release", rxs, 1'b0);

      // R2, R5: ticks before any enable
      for (int i = 0; i < 6; i++) drive(1, 0, 0, 1, 1, 0, 0, 0, 1, "R2 R5 unarmed");

      // R2, R3, R4: one-cycle enable pulse, then free running
      drive(1, 1, 0, 0, 0, 0, 0, 0, 1, "R2 arming");
      for (int i = 0; i < 12; i++)
         drive(logic'(i % 2 == 0), 0, 0, logic'(i % 3 == 0), 0, 0, 0, 0, 1, "R3 R4 R5 tx running");

      // R5, R6, R7: async receive clock gated to character time
      drive(0, 0, 1, 0, 0, 0, 0, 0, 1, "R5 arming");
      for (int i = 0; i < 4; i++) drive(1, 0, 0, 0, 0, 0, 0, 0, 1, "R6 async gap");
      for (int i = 0; i < 5; i++) drive(1, 0, 0, 0, 1, 0, 0, 0, 1, "R6 R7 async char");
      for (int i = 0; i < 4; i++) drive(1, 0, 0, 0, 0, 0, 0, 0, 1, "R6 async hold high");

      // R6: synchronous mode runs without character flag
      for (int i = 0; i < 6; i++) drive(1, 0, 0, 1, 0, 0, 0, 0, 1, "R6 sync");

      // R8: ready function, compare boundaries
      drive(1, 0, 0, 1, 0, 0, 1, 3, 8, "R8 below");
      drive(1, 0, 0, 1, 0, 0, 1, 8, 8, "R8 equal");
      drive(0, 0, 0, 1, 0, 0, 1, 12, 8, "R8 above");
      drive(1, 0, 0, 1, 0, 0, 1, 7, 8, "R8 drop below");
      drive(1, 0, 0, 1, 0, 0, 1, 0, 0, "R8 zero threshold");
      drive(1, 0, 0, 1, 0, 0, 1, 62, 63, "R8 top below");
      drive(1, 0, 0, 1, 0, 0, 1, 63, 63, "R8 top equal");
      for (int i = 0; i < 3; i++) drive(1, 0, 0, 1, 0, 0, 0, 0, 1, "R8 R3 clock back");

      // R9: external receive clock parks the output
      drive(1, 0, 0, 1, 0, 0, 0, 0, 1, "R9 pre");
      for (int i = 0; i < 5; i++) drive(1, 0, 0, 1, 1, 1, 0, 0, 1, "R9 parked");
      for (int i = 0; i < 3; i++) drive(1, 0, 0, 1, 0, 0, 0, 0, 1, "R9 released");

      drive(0, 0, 0, 1, 0, 0, 0, 0, 1, "R3 final idle");
      repeat (3) @(negedge clk);
      chk("R7 scoreboard drained", logic'(exp_q.size() == 0), 1'b1);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule